// File: doc/BRIEF.md
# Signed Double-Width Integer Divider

This block is a multi-cycle signed integer divider. Its dividend is twice as wide as its operands, and a size code picks operand widths of 8, 16, 32 or 64 bits. A start pulse loads the operands. The unit then works on magnitudes with a restoring shift-subtract loop that yields one quotient bit per clock. A final stage applies the signs and checks the result range.

The result is a quotient and a remainder, each the operand width. Division truncates toward zero, and the remainder carries the sign of the dividend. Two conditions report a dedicated divide error instead of a result:

- a zero divisor;
- a quotient that does not fit the signed operand range.

When the error is reported, the previous result stays on the outputs. For the byte size, the two results are also presented packed into one 16-bit word.

Top module: `sdiv_wide`

## Requirements
- R1: The size code selects the operand width n: code 0 is 32 bits (the all-zero default), 1 is 8, 2 is 16 and 3 is 64. The dividend is taken from the low 2n bits of `dividend` and the divisor from the low n bits of `divisor`, each as a signed value. Higher input bits are ignored.
- R2: The quotient is the exact quotient truncated toward zero, presented sign-extended to 64 bits on `quotient`.
- R3: The remainder, sign-extended to 64 bits on `remainder`, satisfies dividend = quotient × divisor + remainder. Its magnitude is below the divisor's, and when nonzero it is negative exactly when the dividend is negative.
- R4: A quotient outside −2^(n−1) .. 2^(n−1)−1 raises `div_err` together with `done`. A quotient of exactly −2^(n−1) is a valid result.
- R5: A zero divisor raises `div_err`, with `done` set by the same clock edge that accepts start.
- R6: When `div_err` is raised, `quotient` and `remainder` keep their previous values. `div_err` is only ever high together with `done`.
- R7: `byte_pair` carries the low byte of the remainder in bits 15:8 and the low byte of the quotient in bits 7:0.
- R8: `done` is a one-cycle pulse. For an operation that runs the loop, it rises n+1 clock edges after the edge that accepts start. `busy` is high from the accepting edge until the edge that raises `done`.
- R9: A start pulse while `busy` is high is ignored: the running operation completes with its own operands.
- R10: Reset, synchronous and active high, clears `busy`, `done`, `div_err`, `quotient` and `remainder`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| size | input | 2 | Operand size code |
| dividend | input | 128 | Double-width signed dividend, low 2n bits used |
| divisor | input | 64 | Signed divisor, low n bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error (zero divisor or quotient overflow) |
| quotient | output | 64 | Signed quotient, sign-extended |
| remainder | output | 64 | Signed remainder, sign-extended |
| byte_pair | output | 16 | Byte-size results packed as remainder:quotient |

## Verification
For byte operands, a strided sweep over the whole 16-bit dividend range is run against a fixed set of divisors. The set covers ±1, ±2, odd values and both range ends, which separates truncation toward zero from floor rounding and shows the sign of each remainder. For every size, corner dividends are combined with corner divisors:

- dividends: most negative, most positive, ±2^n and ±2^(n−1);
- divisors: ±1, ±2, zero, and both range ends.

These combinations separate accepted −2^(n−1) quotients from the overflowing +2^(n−1) case, and early errors from late ones. Random operands with garbage in the unused upper bits check that the size code alone decides which bits count. A start pulse injected mid-run checks that the running operation keeps its operands.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [1:0] {
    SZ_W32 = 2'd0,
    SZ_W8  = 2'd1,
    SZ_W16 = 2'd2,
    SZ_W64 = 2'd3
  } opsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } dstate_e;

  function automatic logic [6:0] op_bits(opsize_e s);
    case (s)
      SZ_W8:   op_bits = 7'd8;
      SZ_W16:  op_bits = 7'd16;
      SZ_W64:  op_bits = 7'd64;
      default: op_bits = 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep
  import sdiv_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  opsize_e                size,
  input  logic [2*MAX_W-1:0]     dividend,
  input  logic [MAX_W-1:0]       divisor,
  output logic [6:0]             nbits,
  output logic                   a_neg,
  output logic                   d_neg,
  output logic [MAX_W-1:0]       hi_mag,
  output logic [MAX_W-1:0]       lo_al,
  output logic [MAX_W-1:0]       d_mag,
  output logic                   early_err
);
  localparam int DW = 2 * MAX_W;

  logic [DW-1:0]           a_sh;
  logic signed [DW-1:0]    a_sx;
  logic [DW-1:0]           a_mag;
  logic [DW-1:0]           hi_full;
  logic [MAX_W-1:0]        d_sh;
  logic signed [MAX_W-1:0] d_sx;
  int unsigned             n;
  int unsigned             sha;
  int unsigned             shd;

  always_comb begin
    nbits   = op_bits(size);
    n       = 32'(nbits);
    sha     = DW - 2 * n;
    shd     = MAX_W - n;
    // sign-extend the selected low 2n dividend bits, then take magnitude
    a_sh    = dividend << sha;
    a_sx    = $signed(a_sh) >>> sha;
    a_neg   = a_sx[DW-1];
    a_mag   = a_neg ? (~a_sx + 1'b1) : a_sx;
    hi_full = a_mag >> n;
    hi_mag  = hi_full[MAX_W-1:0];
    lo_al   = a_mag[MAX_W-1:0] << shd;
    // same for the low n divisor bits
    d_sh    = divisor << shd;
    d_sx    = $signed(d_sh) >>> shd;
    d_neg   = d_sx[MAX_W-1];
    d_mag   = d_neg ? (~d_sx + 1'b1) : d_sx;
    // zero divisor, or magnitude quotient would need more than n bits
    early_err = (d_mag == '0) || (hi_full >= {{MAX_W{1'b0}}, d_mag});
  end

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int MAX_W = 64
) (
  input  logic [MAX_W-1:0] rem_in,
  input  logic             bit_in,
  input  logic [MAX_W-1:0] d_mag,
  output logic [MAX_W-1:0] rem_out,
  output logic             q_bit
);
  logic [MAX_W:0] trial;
  logic [MAX_W:0] diff;

  always_comb begin
    trial   = {rem_in, bit_in};
    diff    = trial - {1'b0, d_mag};
    q_bit   = (trial >= {1'b0, d_mag});
    rem_out = q_bit ? diff[MAX_W-1:0] : trial[MAX_W-1:0];
  end

endmodule

// File: rtl/sdiv_fix.sv
module sdiv_fix #(
  parameter int MAX_W = 64
) (
  input  logic [MAX_W-1:0] q_mag,
  input  logic [MAX_W-1:0] r_mag,
  input  logic             a_neg,
  input  logic             d_neg,
  input  logic [6:0]       nbits,
  output logic [MAX_W-1:0] q_out,
  output logic [MAX_W-1:0] r_out,
  output logic             ovf
);
  logic             q_neg;
  logic [MAX_W-1:0] lim;

  always_comb begin
    q_neg = a_neg ^ d_neg;
    lim   = {{(MAX_W-1){1'b0}}, 1'b1} << (nbits - 7'd1);
    // negative results may reach -2^(n-1), positive ones stop at 2^(n-1)-1
    ovf   = q_neg ? (q_mag > lim) : (q_mag >= lim);
    q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
    r_out = a_neg ? (~r_mag + 1'b1) : r_mag;
  end

endmodule

// File: rtl/sdiv_wide.sv
module sdiv_wide
  import sdiv_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           size,
  input  logic [2*MAX_W-1:0]   dividend,
  input  logic [MAX_W-1:0]     divisor,
  output logic                 busy,
  output logic                 done,
  output logic                 div_err,
  output logic [MAX_W-1:0]     quotient,
  output logic [MAX_W-1:0]     remainder,
  output logic [15:0]          byte_pair
);
  dstate_e          st;
  logic [6:0]       cnt;
  logic [6:0]       n_r;
  logic [MAX_W-1:0] rem_r;
  logic [MAX_W-1:0] lo_r;
  logic [MAX_W-1:0] qm_r;
  logic [MAX_W-1:0] dmag_r;
  logic             an_r;
  logic             dn_r;

  logic [6:0]       p_n;
  logic             p_aneg;
  logic             p_dneg;
  logic [MAX_W-1:0] p_hi;
  logic [MAX_W-1:0] p_lo;
  logic [MAX_W-1:0] p_dmag;
  logic             p_err;
  logic [MAX_W-1:0] s_rem;
  logic             s_bit;
  logic [MAX_W-1:0] f_q;
  logic [MAX_W-1:0] f_r;
  logic             f_ovf;

  sdiv_prep #(.MAX_W(MAX_W)) u_prep (
    .size      (opsize_e'(size)),
    .dividend  (dividend),
    .divisor   (divisor),
    .nbits     (p_n),
    .a_neg     (p_aneg),
    .d_neg     (p_dneg),
    .hi_mag    (p_hi),
    .lo_al     (p_lo),
    .d_mag     (p_dmag),
    .early_err (p_err)
  );

  sdiv_step #(.MAX_W(MAX_W)) u_step (
    .rem_in  (rem_r),
    .bit_in  (lo_r[MAX_W-1]),
    .d_mag   (dmag_r),
    .rem_out (s_rem),
    .q_bit   (s_bit)
  );

  sdiv_fix #(.MAX_W(MAX_W)) u_fix (
    .q_mag (qm_r),
    .r_mag (rem_r),
    .a_neg (an_r),
    .d_neg (dn_r),
    .nbits (n_r),
    .q_out (f_q),
    .r_out (f_r),
    .ovf   (f_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      div_err   <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      cnt       <= '0;
      n_r       <= 7'd32;
      rem_r     <= '0;
      lo_r      <= '0;
      qm_r      <= '0;
      dmag_r    <= '0;
      an_r      <= 1'b0;
      dn_r      <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (p_err) begin
              done    <= 1'b1;
              div_err <= 1'b1;
            end else begin
              st     <= ST_RUN;
              busy   <= 1'b1;
              cnt    <= p_n;
              n_r    <= p_n;
              rem_r  <= p_hi;
              lo_r   <= p_lo;
              qm_r   <= '0;
              dmag_r <= p_dmag;
              an_r   <= p_aneg;
              dn_r   <= p_dneg;
            end
          end
        end
        ST_RUN: begin
          rem_r <= s_rem;
          lo_r  <= lo_r << 1;
          qm_r  <= {qm_r[MAX_W-2:0], s_bit};
          cnt   <= cnt - 7'd1;
          if (cnt == 7'd1) st <= ST_FIX;
        end
        ST_FIX: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
          if (f_ovf) begin
            div_err <= 1'b1;
          end else begin
            quotient  <= f_q;
            remainder <= f_r;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign byte_pair = {remainder[7:0], quotient[7:0]};

endmodule

// File: rtl/sdiv_wide_chk.sv
module sdiv_wide_chk
  import sdiv_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         size,
  input logic [2*MAX_W-1:0] dividend,
  input logic [MAX_W-1:0]   divisor,
  input logic               busy,
  input logic               done,
  input logic               div_err,
  input logic [MAX_W-1:0]   quotient,
  input logic [MAX_W-1:0]   remainder
);
  logic [6:0] nb;
  logic [6:0] sidx;
  logic       cap_aneg;
  logic       cap_dz;

  always_comb begin
    nb   = op_bits(opsize_e'(size));
    sidx = 7'({nb, 1'b0} - 8'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_aneg <= 1'b0;
      cap_dz   <= 1'b0;
    end else if (start && !busy) begin
      cap_aneg <= dividend[sidx];
      cap_dz   <= ((divisor << (7'(MAX_W) - nb)) == '0);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    div_err |-> done); // R6
  AST_ERR_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    div_err |-> ($stable(quotient) && $stable(remainder))); // R6
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (done && cap_dz) |-> div_err); // R5
  AST_REM_SIGN: assert property (@(posedge clk) disable iff (rst)
    (done && !div_err && (remainder != '0)) |-> (remainder[MAX_W-1] == cap_aneg)); // R3

endmodule

bind sdiv_wide sdiv_wide_chk #(.MAX_W(MAX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .size      (size),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .div_err   (div_err),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/sdiv_wide_bench.sv
module sdiv_wide_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   size = 2'd0;
  logic [127:0] dividend = '0;
  logic [63:0]  divisor = '0;
  logic         busy;
  logic         done;
  logic         div_err;
  logic [63:0]  quotient;
  logic [63:0]  remainder;
  logic [15:0]  byte_pair;

  int total = 0;
  int bad = 0;
  logic [63:0] last_q = '0;
  logic [63:0] last_r = '0;

  always #5 clk = ~clk;

  sdiv_wide u_sdiv_wide (
    .clk(clk), .rst(rst), .start(start), .size(size),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_err(div_err), .quotient(quotient), .remainder(remainder),
    .byte_pair(byte_pair)
  );

  function automatic int bits_of(logic [1:0] c);
    case (c)
      2'd1: return 8;
      2'd2: return 16;
      2'd3: return 64;
      default: return 32;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_div(input logic [1:0] sz, input logic [127:0] dvd, input logic [63:0] dsr, input bit inject);
    int n;
    int cnt;
    logic signed [127:0] t;
    logic signed [63:0]  u;
    logic signed [129:0] dv, ds, q, r, lim;
    logic exp_err;
    n = bits_of(sz);
    t = $signed(dvd << (128 - 2 * n));
    t = t >>> (128 - 2 * n);
    u = $signed(dsr << (64 - n));
    u = u >>> (64 - n);
    dv = t;
    ds = u;
    lim = 130'sd1 <<< (n - 1);
    if (ds == 0) begin
      exp_err = 1'b1;
      q = 0;
      r = 0;
    end else begin
      q = dv / ds;
      r = dv % ds;
      exp_err = (q >= lim) || (q < -lim);
    end
    @(negedge clk);
    size = sz;
    dividend = dvd;
    divisor = dsr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 300) begin
      if (inject && cnt == 3) begin
        start = 1'b1;
        dividend = ~dvd;
        divisor = dsr + 64'd3;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    chk(done == 1'b1, "R8 done seen", 128'(done), 128'(1));
    if (exp_err) begin
      chk(div_err == 1'b1, (ds == 0) ? "R5 zero divisor error" : "R4 overflow error", 128'(div_err), 128'(1));
      chk(quotient == last_q && remainder == last_r, "R6 results held on error",
          {quotient, remainder}, {last_q, last_r});
      if (ds == 0) chk(cnt == 1, "R5 error at accepting edge", 128'(cnt), 128'(1));
    end else begin
      chk(div_err == 1'b0, "R4 no error in range", 128'(div_err), 128'(0));
      chk(quotient == q[63:0], "R2 quotient", 128'(quotient), 128'(q[63:0]));
      chk(remainder == r[63:0], "R3 remainder", 128'(remainder), 128'(r[63:0]));
      chk(cnt == n + 2, "R8 latency", 128'(cnt), 128'(n + 2));
      if (sz == 2'd1) chk(byte_pair == {r[7:0], q[7:0]}, "R7 byte pair", 128'(byte_pair), 128'({r[7:0], q[7:0]}));
      if (inject) chk(quotient == q[63:0], "R9 start ignored while busy", 128'(quotient), 128'(q[63:0]));
      last_q = q[63:0];
      last_r = r[63:0];
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done is one pulse", 128'(done), 128'(0));
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bdiv[14] = '{-128, -127, -64, -5, -3, -2, -1, 0, 1, 2, 3, 7, 64, 127};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && done == 0 && div_err == 0, "R10 reset flags", {busy, done, div_err}, 0);
    chk(quotient == 0 && remainder == 0, "R10 reset results", {quotient, remainder}, 0);

    // byte sweep (R1 code 1, R2, R3, R4, R7)
    for (int a = -32768; a < 32768; a += 131) begin
      for (int k = 0; k < 14; k++) begin
        logic signed [127:0] x;
        logic signed [63:0]  y;
        x = a;
        y = bdiv[k];
        run_div(2'd1, x, y, 1'b0);
      end
    end

    // corners for every size (R4 boundary, R5)
    for (int c = 0; c < 4; c++) begin
      int n;
      logic signed [129:0] dl[10];
      logic signed [129:0] vl[7];
      n = bits_of(2'(c));
      dl[0] = -(130'sd1 <<< (2 * n - 1));
      dl[1] = dl[0] + 1;
      dl[2] = -1;
      dl[3] = 0;
      dl[4] = 1;
      dl[5] = (130'sd1 <<< (2 * n - 1)) - 1;
      dl[6] = -(130'sd1 <<< n);
      dl[7] = 130'sd1 <<< n;
      dl[8] = -(130'sd1 <<< (n - 1));
      dl[9] = (130'sd1 <<< (n - 1)) - 1;
      vl[0] = 1;
      vl[1] = -1;
      vl[2] = 0;
      vl[3] = 2;
      vl[4] = -2;
      vl[5] = (130'sd1 <<< (n - 1)) - 1;
      vl[6] = -(130'sd1 <<< (n - 1));
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 7; j++)
          run_div(2'(c), dl[i][127:0], vl[j][63:0], 1'b0);
    end

    // random with garbage above the selected width (R1), one injected start per size (R9)
    for (int c = 0; c < 4; c++) begin
      int n;
      n = bits_of(2'(c));
      for (int i = 0; i < 100; i++) begin
        logic [127:0] r1, r2, m2, dvd;
        logic [63:0]  s1, s2, m1, dsr;
        logic signed [127:0] t;
        logic signed [63:0]  u;
        int ka, kd;
        r1 = {$urandom(), $urandom(), $urandom(), $urandom()};
        r2 = {$urandom(), $urandom(), $urandom(), $urandom()};
        s1 = {$urandom(), $urandom()};
        s2 = {$urandom(), $urandom()};
        ka = $urandom_range(2 * n, 1);
        kd = $urandom_range(n, 1);
        t = $signed(r1 << (128 - ka));
        t = t >>> (128 - ka);
        u = $signed(s1 << (64 - kd));
        u = u >>> (64 - kd);
        m2 = (128'd1 << (2 * n)) - 128'd1;
        m1 = (64'd1 << n) - 64'd1;
        dvd = (t & m2) | (r2 & ~m2);
        dsr = (u & m1) | (s2 & ~m1);
        run_div(2'(c), dvd, dsr, 1'b0);
      end
      run_div(2'(c), 128'sd1000, 64'sd7, 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule